// File: doc/BRIEF.md
# UART FIFO Controller with Receive Timeout

This block holds the transmit and receive byte queues of a 16550-class serial port, together with the control register that configures them. A write to the control register can enable both queues, flush either one, choose a DMA signalling mode and pick a receive threshold. The register only takes a write when that same write also sets the enable bit. Flush requests act once and never read back as set. Clearing the enable bit empties both queues.

On the receive side, the block raises a data-available flag once the occupancy reaches the selected threshold. It raises a character-timeout flag when bytes have waited in the queue, with no push or pop, for four character times. The surrounding serial logic supplies a one-cycle character-time tick. The shift registers, baud generation, DMA ready pins and interrupt prioritisation live outside this block. A flush never touches them.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: A control write with bit 0 set stores the threshold code from bits 7:6, the DMA select from bit 3 and enable = 1. The readback `cfg_o` returns these bits in the same positions, and bits 5:4 and 2:1 always read 0.
- R2: A control write with bit 0 clear sets enable to 0 and leaves the stored threshold code and DMA select unchanged.
- R3: A write with bits 0 and 1 set empties the receive queue at that clock edge. A write with bits 0 and 2 set does the same for the transmit queue. Each flush leaves the other queue untouched.
- R4: While enable is 0, both queues are emptied from the second edge after the disabling write onward, and pushes are dropped.
- R5: Each queue holds 16 bytes in first-in-first-out order. The data output shows the oldest byte and the count output shows the occupancy.
- R6: A push into a full queue is dropped. On the receive queue it sets a sticky overrun flag, which a receive flush or disable clears.
- R7: A pop from an empty queue has no effect.
- R8: `rx_avail_o` is high while enabled and the receive count is at least the threshold. The threshold codes are 00 = 1 byte, 01 = 4 bytes, 10 = 8 bytes and 11 = 14 bytes.
- R9: With the receive queue non-empty and no push or pop on it, `rx_timeout_o` rises after the edge that samples the fourth character tick.
- R10: A receive push or pop restarts the idle count, and a receive pop drops `rx_timeout_o` after that edge.
- R11: `rx_timeout_o` is low while the receive queue is empty or enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_o | output | 8 | Control register readback |
| dma_mode_o | output | 1 | Stored DMA signalling select |
| tx_push_i | input | 1 | Push a byte into the transmit queue |
| tx_data_i | input | 8 | Transmit push data |
| tx_pop_i | input | 1 | Pop the oldest transmit byte |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_count_o | output | 5 | Transmit occupancy |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_push_i | input | 1 | Push a received byte |
| rx_data_i | input | 8 | Receive push data |
| rx_pop_i | input | 1 | Pop the oldest received byte |
| rx_data_o | output | 8 | Oldest received byte |
| rx_count_o | output | 5 | Receive occupancy |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| char_tick_i | input | 1 | One-cycle pulse per character time |
| rx_avail_o | output | 1 | Receive occupancy at or above threshold |
| rx_timeout_o | output | 1 | Receive character timeout |
| rx_overrun_o | output | 1 | Sticky receive overrun |

## Verification
Register readback, queue counts, queue data and overrun all change on the edge that samples the request. A disable empties the queues one edge later, because the stored enable bit drives the flush. The timeout rises on the edge that samples the fourth tick. `rx_avail_o` follows the count with no extra register. The bench drives every input at a falling edge, holds it across one rising edge and compares at the next falling edge. For a disable, it lets one idle cycle pass before checking.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_RX_CLR = 1;
  localparam int unsigned BIT_TX_CLR = 2;
  localparam int unsigned BIT_DMA    = 3;
  localparam int unsigned BIT_TRIG   = 6;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } rx_trig_e;

  typedef struct packed {
    rx_trig_e trig;
    logic     dma;
    logic     en;
  } fifo_cfg_t;

  function automatic int unsigned trig_bytes(rx_trig_e t);
    case (t)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/uart_fifo_cfg_reg.sv
module uart_fifo_cfg_reg
  import uart_fifo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output fifo_cfg_t  cfg_o,
  output logic       flush_tx_o,
  output logic       flush_rx_o,
  output logic [7:0] rdata_o
);
  fifo_cfg_t cfg_q;
  logic      unused_wbits;

  assign unused_wbits = ^wdata_i[5:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{trig: TRIG_1, dma: 1'b0, en: 1'b0};
    end else if (we_i) begin
      if (wdata_i[BIT_EN]) begin
        cfg_q.trig <= rx_trig_e'(wdata_i[BIT_TRIG+:2]);
        cfg_q.dma  <= wdata_i[BIT_DMA];
        cfg_q.en   <= 1'b1;
      end else begin
        cfg_q.en   <= 1'b0;  // other bits of this write ignored
      end
    end
  end

  // flush strobes live for the write cycle only: self-clearing
  assign flush_tx_o = we_i & wdata_i[BIT_EN] & wdata_i[BIT_TX_CLR];
  assign flush_rx_o = we_i & wdata_i[BIT_EN] & wdata_i[BIT_RX_CLR];

  assign cfg_o   = cfg_q;
  assign rdata_o = {cfg_q.trig, 2'b00, cfg_q.dma, 2'b00, cfg_q.en};
endmodule

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic          drop_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + AW'(1);
  endfunction

  assign full_o    = (cnt_q == FULL_CNT);
  assign empty_o   = (cnt_q == '0);
  assign pop_ok_o  = pop_i & ~empty_o & ~clr_i;
  assign push_ok_o = push_i & ~clr_i & (~full_o | pop_ok_o);
  assign drop_o    = push_i & ~clr_i & full_o & ~pop_ok_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok_o) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok_o)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok_o, pop_ok_o})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wr_ptr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
  parameter int unsigned CHAR_LIMIT = 4,
  localparam int unsigned TW        = $clog2(CHAR_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic empty_i,
  input  logic activity_i,
  input  logic tick_i,
  output logic timeout_o
);
  localparam logic [TW-1:0] LIMIT = TW'(CHAR_LIMIT);

  logic [TW-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
    end else if (!en_i || empty_i || activity_i) begin
      idle_q <= '0;
    end else if (tick_i && idle_q != LIMIT) begin
      idle_q <= idle_q + TW'(1);  // saturates at the limit
    end
  end

  assign timeout_o = en_i & ~empty_i & (idle_q == LIMIT);
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned CHAR_LIMIT = 4,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_o,
  output logic              dma_mode_o,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [CW-1:0]     tx_count_o,
  output logic              tx_full_o,
  output logic              tx_empty_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [CW-1:0]     rx_count_o,
  output logic              rx_full_o,
  output logic              rx_empty_o,
  input  logic              char_tick_i,
  output logic              rx_avail_o,
  output logic              rx_timeout_o,
  output logic              rx_overrun_o
);
  fifo_cfg_t cfg;
  logic      flush_tx, flush_rx, tx_clr, rx_clr;
  logic      tx_push_ok, tx_pop_ok, tx_drop;
  logic      rx_push_ok, rx_pop_ok, rx_drop;
  logic      unused_tx;
  logic      ovr_q;

  uart_fifo_cfg_reg u_cfg (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .cfg_o     (cfg),
    .flush_tx_o(flush_tx),
    .flush_rx_o(flush_rx),
    .rdata_o   (cfg_o)
  );

  assign tx_clr = ~cfg.en | flush_tx;
  assign rx_clr = ~cfg.en | flush_rx;

  uart_fifo_buf #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_buf (
    .clk_i, .rst_ni,
    .clr_i    (tx_clr),
    .push_i   (tx_push_i),
    .data_i   (tx_data_i),
    .pop_i    (tx_pop_i),
    .data_o   (tx_data_o),
    .count_o  (tx_count_o),
    .full_o   (tx_full_o),
    .empty_o  (tx_empty_o),
    .push_ok_o(tx_push_ok),
    .pop_ok_o (tx_pop_ok),
    .drop_o   (tx_drop)
  );
  assign unused_tx = tx_push_ok ^ tx_pop_ok ^ tx_drop;

  uart_fifo_buf #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_buf (
    .clk_i, .rst_ni,
    .clr_i    (rx_clr),
    .push_i   (rx_push_i),
    .data_i   (rx_data_i),
    .pop_i    (rx_pop_i),
    .data_o   (rx_data_o),
    .count_o  (rx_count_o),
    .full_o   (rx_full_o),
    .empty_o  (rx_empty_o),
    .push_ok_o(rx_push_ok),
    .pop_ok_o (rx_pop_ok),
    .drop_o   (rx_drop)
  );

  uart_rx_timeout #(.CHAR_LIMIT(CHAR_LIMIT)) u_tmo (
    .clk_i, .rst_ni,
    .en_i      (cfg.en),
    .empty_i   (rx_empty_o),
    .activity_i(rx_push_ok | rx_pop_ok),
    .tick_i    (char_tick_i),
    .timeout_o (rx_timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovr_q <= 1'b0;
    else if (rx_clr)   ovr_q <= 1'b0;
    else if (rx_drop)  ovr_q <= 1'b1;
  end

  assign rx_overrun_o = ovr_q;
  assign dma_mode_o   = cfg.dma;
  assign rx_avail_o   = cfg.en & (32'(rx_count_o) >= trig_bytes(cfg.trig));
endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [7:0]    cfg_wdata_i,
  input logic [7:0]    cfg_o,
  input logic          rx_push_i,
  input logic          rx_pop_i,
  input logic [CW-1:0] rx_count_o,
  input logic [CW-1:0] tx_count_o,
  input logic          rx_full_o,
  input logic          rx_empty_o,
  input logic          rx_avail_o,
  input logic          rx_timeout_o,
  input logic          rx_overrun_o
);
  // R2
  en_off_keeps_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_wdata_i[0]) |=> (!cfg_o[0] && cfg_o[7:6] == $past(cfg_o[7:6])
                                       && cfg_o[3] == $past(cfg_o[3])));
  // R3
  rx_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[0] && cfg_wdata_i[1]) |=> (rx_count_o == '0));
  // R3
  tx_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[0] && cfg_wdata_i[2]) |=> (tx_count_o == '0));
  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(rx_count_o) <= FIFO_DEPTH));
  // R6
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o[0] && !cfg_we_i && rx_push_i && rx_full_o && !rx_pop_i) |=> rx_overrun_o);
  // R8
  avail_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_avail_o |-> !rx_empty_o);
  // R10
  pop_clears_tmo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_i && !rx_empty_o) |=> !rx_timeout_o);
  // R11
  tmo_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_timeout_o |-> (!rx_empty_o && cfg_o[0]));
endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_o       (cfg_o),
  .rx_push_i   (rx_push_i),
  .rx_pop_i    (rx_pop_i),
  .rx_count_o  (rx_count_o),
  .tx_count_o  (tx_count_o),
  .rx_full_o   (rx_full_o),
  .rx_empty_o  (rx_empty_o),
  .rx_avail_o  (rx_avail_o),
  .rx_timeout_o(rx_timeout_o),
  .rx_overrun_o(rx_overrun_o)
);

// File: tb/uart_fifo_ctrl_tb.sv
module uart_fifo_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rd;
  logic       dma_mode;
  logic       tx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0] tx_din = '0, tx_dout;
  logic [4:0] tx_count;
  logic       tx_full, tx_empty;
  logic       rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] rx_din = '0, rx_dout;
  logic [4:0] rx_count;
  logic       rx_full, rx_empty;
  logic       tick = 1'b0;
  logic       rx_avail, rx_tmo, rx_ovr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_fifo_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_o(cfg_rd), .dma_mode_o(dma_mode),
    .tx_push_i(tx_push), .tx_data_i(tx_din), .tx_pop_i(tx_pop), .tx_data_o(tx_dout),
    .tx_count_o(tx_count), .tx_full_o(tx_full), .tx_empty_o(tx_empty),
    .rx_push_i(rx_push), .rx_data_i(rx_din), .rx_pop_i(rx_pop), .rx_data_o(rx_dout),
    .rx_count_o(rx_count), .rx_full_o(rx_full), .rx_empty_o(rx_empty),
    .char_tick_i(tick), .rx_avail_o(rx_avail), .rx_timeout_o(rx_tmo), .rx_overrun_o(rx_ovr)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic rx_put(logic [7:0] d);
    @(negedge clk); rx_push = 1'b1; rx_din = d;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic tx_put(logic [7:0] d);
    @(negedge clk); tx_push = 1'b1; tx_din = d;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic rx_get(output logic [7:0] d);
    @(negedge clk); d = rx_dout; rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic tx_get(output logic [7:0] d);
    @(negedge clk); d = tx_dout; tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  function automatic int thr(int code);
    return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    // reset state
    check("R1 reset cfg", cfg_rd, 0);
    check("R4 reset rx empty", rx_empty, 1);
    check("R11 reset timeout", rx_tmo, 0);

    // R1 decode and readback
    wr(8'hF9);
    check("R1 readback", cfg_rd, 8'hC9);
    check("R1 dma_mode", dma_mode, 1);
    // R2 write without enable
    wr(8'h7A);
    check("R2 readback", cfg_rd, 8'hC8);
    check("R2 dma kept", dma_mode, 1);
    wr(8'h07);
    check("R3 self-clear readback", cfg_rd, 8'h01);

    // R8 threshold sweep with R5 ordering
    for (int code = 0; code < 4; code++) begin
      wr(8'((code << 6) | 3));
      check("R8 empty no avail", rx_avail, 0);
      for (int n = 1; n <= 16; n++) begin
        rx_put(8'(code * 16 + n));
        check("R5 rx count", rx_count, n);
        check("R8 avail vs threshold", rx_avail, (n >= thr(code)) ? 1 : 0);
      end
      check("R5 rx full", rx_full, 1);
      for (int n = 1; n <= 16; n++) begin
        rx_get(d);
        check("R5 rx order", d, code * 16 + n);
      end
      check("R5 rx empty after drain", rx_empty, 1);
      rx_get(d);
      check("R7 pop empty count", rx_count, 0);
    end

    // R6 overrun on full rx, full tx drop
    wr(8'h07);
    for (int n = 0; n < 16; n++) rx_put(8'(n));
    check("R6 no overrun at full", rx_ovr, 0);
    rx_put(8'hAA);
    check("R6 count held", rx_count, 16);
    check("R6 overrun set", rx_ovr, 1);
    rx_get(d);
    check("R6 oldest kept", d, 0);
    check("R6 overrun sticky", rx_ovr, 1);
    wr(8'h03);
    check("R6 overrun cleared by flush", rx_ovr, 0);
    check("R3 rx flushed", rx_count, 0);
    for (int n = 0; n < 17; n++) tx_put(8'(n + 100));
    check("R6 tx count held", tx_count, 16);
    tx_get(d);
    check("R6 tx oldest", d, 100);

    // R3 flush isolation
    rx_put(8'h11); rx_put(8'h22);
    wr(8'h05);
    check("R3 tx flushed", tx_count, 0);
    check("R3 rx untouched", rx_count, 2);
    tx_put(8'h33);
    wr(8'h03);
    check("R3 rx flushed only", rx_count, 0);
    check("R3 tx untouched", tx_count, 1);

    // R9 / R10 timeout
    rx_put(8'h44);
    for (int t = 0; t < 3; t++) pulse_tick();
    check("R9 no timeout at 3 ticks", rx_tmo, 0);
    pulse_tick();
    check("R9 timeout at 4 ticks", rx_tmo, 1);
    pulse_tick();
    check("R9 timeout holds", rx_tmo, 1);
    rx_get(d);
    check("R10 pop clears timeout", rx_tmo, 0);
    check("R11 empty no timeout", rx_empty, 1);
    for (int t = 0; t < 5; t++) pulse_tick();
    check("R11 empty never times out", rx_tmo, 0);
    rx_put(8'h01); rx_put(8'h02);
    for (int t = 0; t < 3; t++) pulse_tick();
    rx_put(8'h03);
    for (int t = 0; t < 3; t++) pulse_tick();
    check("R10 push restarts count", rx_tmo, 0);
    pulse_tick();
    check("R10 timeout after restart", rx_tmo, 1);
    rx_get(d);
    check("R10 pop drops timeout", rx_tmo, 0);
    for (int t = 0; t < 4; t++) pulse_tick();
    check("R10 timeout again after pop", rx_tmo, 1);

    // R4 / R11 disable
    wr(8'h00);
    check("R11 disable drops timeout", rx_tmo, 0);
    idle();
    check("R4 rx emptied", rx_count, 0);
    check("R4 tx emptied", tx_count, 0);
    rx_put(8'h55); tx_put(8'h66);
    check("R4 rx push dropped", rx_count, 0);
    check("R4 tx push dropped", tx_count, 0);
    check("R4 no avail disabled", rx_avail, 0);
    wr(8'h01);
    check("R2 enable restores", cfg_rd, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule